// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the host-facing register file of an enhanced UART. A host reaches it through a 3-bit address, a chip select, separate read and write strobes and an 8-bit data bus. Eight addresses cannot hold every register, so the contents of the line control register pick one of three banks. The normal bank holds the everyday control registers. The divisor bank puts the two baud-divisor bytes at the two lowest addresses. The enhanced bank adds a feature-enable register and four software flow-control characters.

The stored values drive neighbouring logic through plain output ports: the 16-bit divisor, the control bytes, the feature byte and the four flow characters. The receive and transmit data paths are not part of this block. For them the decoder issues one-cycle read and write pulses whenever the normal bank is selected. An access takes effect once, in its first cycle, however long the host holds the strobe.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset every stored register reads 0x00, every output port is 0, and the normal bank is selected.
- R2: When line control bit 7 is 1 and the line control byte is not 0xBF, address 0 reads and writes the divisor low byte and address 1 the divisor high byte (`divisor` = {high, low}). Addresses 2 to 7 keep their normal-bank meaning.
- R3: A line control value of exactly 0xBF selects the enhanced bank, even though its bit 7 is also 1.
- R4: In the enhanced bank, when both divisor bytes are 0x00, a read at address 0 returns the revision byte (parameter, default 0x01) and a read at address 1 returns 0x04. Otherwise those two addresses read the divisor bytes. Writes there always update the divisor.
- R5: In the enhanced bank, address 2 reads and writes the feature register. Bit 7 enables auto CTS, bit 6 auto RTS, bit 5 special-character detection, bit 4 is the extended-bit write enable, and bits 3:0 select the software flow mode.
- R6: In the enhanced bank, addresses 4, 5, 6 and 7 read and write the first on-character, second on-character, first off-character and second off-character. These appear on `flow_chars` bits 7:0, 15:8, 23:16 and 31:24.
- R7: While feature bit 4 is 0, writes leave interrupt-enable bits 7:4, FIFO-control bits 5:4 and modem-control bits 7:5 unchanged, and the remaining bits are still written. While it is 1, the whole byte is written.
- R8: Address 3 accesses the line control register in every bank.
- R9: In the normal bank, reads at address 0 (receive stub), 2 (status stub), 5 and 6 return 0x00. Writes to 5 and 6 change nothing, and a write at address 0 goes only to the transmit strobe. Addresses 1, 4 and 7 hold interrupt enable, modem control and a scratch byte, and a write at address 2 sets the FIFO-control byte.
- R10: `nb_rd_stb` and `nb_wr_stb` pulse for exactly the first cycle of a read or write access while the normal bank is selected, and never in the other banks.
- R11: A write held for several cycles stores only the data present in its first cycle.
- R12: `rdata` is 0x00 whenever chip select and read are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| nb_rd_stb | output | 1 | One-cycle normal-bank read pulse |
| nb_wr_stb | output | 1 | One-cycle normal-bank write pulse |
| divisor | output | 16 | Baud divisor {high, low} |
| lcr_o | output | 8 | Line control byte |
| ier_o | output | 8 | Interrupt enable byte |
| fcr_o | output | 8 | FIFO control byte |
| mcr_o | output | 8 | Modem control byte |
| efr_o | output | 8 | Feature enable byte |
| flow_chars | output | 32 | Four flow-control characters |

## Verification
A corrupted line control byte changes which register answers at addresses 0, 1, 2 and 4 to 7. That shows up on `rdata` at the next read, and on the strobes in the same cycle as the access. A wrong divisor or feature bit shows on its output port one cycle after the write, and a zero divisor also changes what the two identification reads return. A lost edge detector shows as a second strobe pulse, or as a second store from a held write, one cycle later. The bench therefore compares every output against its model on every clock.

// File: rtl/uart_bank_regs.sv
module uart_bank_regs #(
  parameter logic [7:0] REV_BYTE = 8'h01,
  parameter logic [7:0] ID_BYTE  = 8'h04,
  parameter logic [7:0] ENH_KEY  = 8'hBF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        rd,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        nb_rd_stb,
  output logic        nb_wr_stb,
  output logic [15:0] divisor,
  output logic [7:0]  lcr_o,
  output logic [7:0]  ier_o,
  output logic [7:0]  fcr_o,
  output logic [7:0]  mcr_o,
  output logic [7:0]  efr_o,
  output logic [31:0] flow_chars
);
  localparam logic [1:0] BK_NORM = 2'd0;
  localparam logic [1:0] BK_DIV  = 2'd1;
  localparam logic [1:0] BK_ENH  = 2'd2;

  logic [7:0] dll, dlm, ier, fcr, lcr, mcr, spr, efr;
  logic [7:0] fc [4];
  logic       rd_q, wr_q;

  logic [1:0] bank;
  logic       rd_go, wr_go;
  logic       sel_div, sel_efr, sel_fc, sel_norm, id_mode;
  logic [7:0] rd_val;

  assign bank = (lcr == ENH_KEY) ? BK_ENH : (lcr[7] ? BK_DIV : BK_NORM);

  assign rd_go = cs & rd & ~rd_q;
  assign wr_go = cs & wr & ~wr_q;

  assign sel_div  = (bank != BK_NORM) && (addr[2:1] == 2'b00);
  assign sel_efr  = (bank == BK_ENH) && (addr == 3'd2);
  assign sel_fc   = (bank == BK_ENH) && addr[2];
  assign sel_norm = !sel_div && !sel_efr && !sel_fc;
  assign id_mode  = (bank == BK_ENH) && (dll == 8'h00) && (dlm == 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      dll  <= '0;
      dlm  <= '0;
      ier  <= '0;
      fcr  <= '0;
      lcr  <= '0;
      mcr  <= '0;
      spr  <= '0;
      efr  <= '0;
      for (int i = 0; i < 4; i++) fc[i] <= '0;
    end else begin
      rd_q <= cs & rd;
      wr_q <= cs & wr;
      if (wr_go) begin
        if (sel_div) begin
          if (addr[0]) dlm <= wdata;
          else         dll <= wdata;
        end else if (sel_efr) begin
          efr <= wdata;
        end else if (sel_fc) begin
          fc[addr[1:0]] <= wdata;
        end else begin
          case (addr)
            3'd1: ier <= efr[4] ? wdata : {ier[7:4], wdata[3:0]};
            3'd2: fcr <= efr[4] ? wdata : {wdata[7:6], fcr[5:4], wdata[3:0]};
            3'd3: lcr <= wdata;
            3'd4: mcr <= efr[4] ? wdata : {mcr[7:5], wdata[4:0]};
            3'd7: spr <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (sel_div) begin
      if (id_mode) rd_val = addr[0] ? ID_BYTE : REV_BYTE;
      else         rd_val = addr[0] ? dlm : dll;
    end else if (sel_efr) begin
      rd_val = efr;
    end else if (sel_fc) begin
      rd_val = fc[addr[1:0]];
    end else begin
      case (addr)
        3'd1:    rd_val = ier;
        3'd3:    rd_val = lcr;
        3'd4:    rd_val = mcr;
        3'd7:    rd_val = spr;
        default: rd_val = 8'h00;
      endcase
    end
  end

  assign rdata      = (cs & rd) ? rd_val : 8'h00;
  assign nb_rd_stb  = rd_go && (bank == BK_NORM);
  assign nb_wr_stb  = wr_go && (bank == BK_NORM);
  assign divisor    = {dlm, dll};
  assign lcr_o      = lcr;
  assign ier_o      = ier;
  assign fcr_o      = fcr;
  assign mcr_o      = mcr;
  assign efr_o      = efr;
  assign flow_chars = {fc[3], fc[2], fc[1], fc[0]};
endmodule

module uart_bank_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs,
  input logic        rd,
  input logic        wr,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        nb_rd_stb,
  input logic        nb_wr_stb,
  input logic [15:0] divisor,
  input logic [7:0]  lcr_o,
  input logic [7:0]  ier_o,
  input logic [7:0]  fcr_o,
  input logic [7:0]  mcr_o,
  input logic [7:0]  efr_o,
  input logic [31:0] flow_chars
);
  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nb_rd_stb |=> !nb_rd_stb);
  assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nb_wr_stb |=> !nb_wr_stb);
  assert_enh_no_stb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_o == 8'hBF) |-> (!nb_rd_stb && !nb_wr_stb));
  assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> (rdata == 8'h00));
  assert_ier_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_o[4] |=> $stable(ier_o[7:4]));
  assert_fcr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_o[4] |=> $stable(fcr_o[5:4]));
  assert_mcr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_o[4] |=> $stable(mcr_o[7:5]));
  assert_id_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && lcr_o == 8'hBF && addr == 3'd1 && divisor == 16'h0000) |-> (rdata == 8'h04));
  assert_lsr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !lcr_o[7] && addr == 3'd5) |-> (rdata == 8'h00));
endmodule

bind uart_bank_regs uart_bank_regs_chk chk_i (.*);

// File: tb/uart_bank_regs_tb.sv
module uart_bank_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        nb_rd_stb, nb_wr_stb;
  logic [15:0] divisor;
  logic [7:0]  lcr_o, ier_o, fcr_o, mcr_o, efr_o;
  logic [31:0] flow_chars;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  byte unsigned m_dll = 0, m_dlm = 0, m_ier = 0, m_fcr = 0, m_lcr = 0;
  byte unsigned m_mcr = 0, m_spr = 0, m_efr = 0;
  byte unsigned m_fc [4] = '{0, 0, 0, 0};
  bit m_rd_prev = 0, m_wr_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_bank_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .nb_rd_stb(nb_rd_stb), .nb_wr_stb(nb_wr_stb),
    .divisor(divisor), .lcr_o(lcr_o), .ier_o(ier_o), .fcr_o(fcr_o),
    .mcr_o(mcr_o), .efr_o(efr_o), .flow_chars(flow_chars)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_bank();
    if (m_lcr == 8'hBF) return 2;
    if (m_lcr >= 8'h80) return 1;
    return 0;
  endfunction

  function automatic byte unsigned m_read(input int a);
    int b = m_bank();
    if (b != 0 && a < 2) begin
      if (b == 2 && m_dll == 0 && m_dlm == 0) return (a == 1) ? 8'h04 : 8'h01;
      return (a == 1) ? m_dlm : m_dll;
    end
    if (b == 2 && a == 2) return m_efr;
    if (b == 2 && a >= 4) return m_fc[a-4];
    if (a == 1) return m_ier;
    if (a == 3) return m_lcr;
    if (a == 4) return m_mcr;
    if (a == 7) return m_spr;
    return 0;
  endfunction

  task automatic m_write(input int a, input byte unsigned d);
    int b = m_bank();
    bit ext = m_efr[4];
    if (b != 0 && a < 2) begin
      if (a == 1) m_dlm = d; else m_dll = d;
    end else if (b == 2 && a == 2) m_efr = d;
    else if (b == 2 && a >= 4) m_fc[a-4] = d;
    else if (a == 1) m_ier = ext ? d : ((m_ier & 8'hF0) | (d & 8'h0F));
    else if (a == 2) m_fcr = ext ? d : ((m_fcr & 8'h30) | (d & 8'hCF));
    else if (a == 3) m_lcr = d;
    else if (a == 4) m_mcr = ext ? d : ((m_mcr & 8'hE0) | (d & 8'h1F));
    else if (a == 7) m_spr = d;
  endtask

  task automatic cyc(input bit c, input bit r, input bit w, input int a, input byte unsigned d);
    bit rgo, wgo;
    @(posedge clk);
    #1;
    cs = c; rd = r; wr = w; addr = a[2:0]; wdata = d;
    @(negedge clk);
    rgo = c && r && !m_rd_prev;
    wgo = c && w && !m_wr_prev;
    chk(cur_req, rdata, (c && r) ? m_read(a) : 8'h00);
    chk("R10 rd strobe", nb_rd_stb, rgo && m_bank() == 0);
    chk("R10 wr strobe", nb_wr_stb, wgo && m_bank() == 0);
    chk("R2 divisor", divisor, {m_dlm, m_dll});
    chk("R8 lcr", lcr_o, m_lcr);
    chk("R7 ier", ier_o, m_ier);
    chk("R7 fcr", fcr_o, m_fcr);
    chk("R7 mcr", mcr_o, m_mcr);
    chk("R5 efr", efr_o, m_efr);
    chk("R6 flow chars", flow_chars, {m_fc[3], m_fc[2], m_fc[1], m_fc[0]});
    if (wgo) m_write(a, d);
    m_rd_prev = c && r;
    m_wr_prev = c && w;
  endtask

  task automatic wr1(input int a, input byte unsigned d);
    cyc(1, 0, 1, a, d);
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic rd1(input int a);
    cyc(1, 1, 0, a, 0);
    cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    cyc(0, 0, 0, 0, 0);
    chk("R1 divisor reset", divisor, 16'h0000);
    chk("R1 efr reset", efr_o, 8'h00);
    for (int a = 0; a < 8; a++) rd1(a);

    cur_req = "R7 gated";
    wr1(1, 8'hFF);
    wr1(2, 8'hFF);
    wr1(4, 8'hFF);
    chk("R7 ier low nibble only", ier_o, 8'h0F);
    chk("R7 fcr bits 5:4 held", fcr_o, 8'hCF);
    chk("R7 mcr bits 7:5 held", mcr_o, 8'h1F);

    cur_req = "R9";
    wr1(7, 8'h5A);
    rd1(7);
    wr1(5, 8'h33);
    wr1(6, 8'h44);
    rd1(5);
    rd1(6);
    rd1(2);
    wr1(0, 8'h77);
    chk("R9 transmit write leaves divisor", divisor, 16'h0000);

    cur_req = "R11";
    cyc(1, 0, 1, 7, 8'hAA);
    cyc(1, 0, 1, 7, 8'h55);
    cyc(1, 0, 1, 7, 8'h66);
    cyc(0, 0, 0, 0, 0);
    rd1(7);
    cyc(1, 1, 0, 1, 0);
    cyc(1, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);

    cur_req = "R12";
    cyc(0, 1, 0, 7, 0);
    cyc(1, 0, 0, 7, 0);

    cur_req = "R2";
    wr1(3, 8'h83);
    wr1(0, 8'h34);
    wr1(1, 8'h12);
    chk("R2 divisor value", divisor, 16'h1234);
    rd1(0);
    rd1(1);
    rd1(7);
    wr1(4, 8'h02);

    cur_req = "R3";
    wr1(3, 8'hBF);
    rd1(3);
    rd1(0);
    rd1(1);

    cur_req = "R5";
    wr1(2, 8'hD5);
    rd1(2);
    chk("R5 feature byte", efr_o, 8'hD5);

    cur_req = "R6";
    wr1(4, 8'h11);
    wr1(5, 8'h13);
    wr1(6, 8'h19);
    wr1(7, 8'h93);
    for (int a = 4; a < 8; a++) rd1(a);
    chk("R6 char order", flow_chars, 32'h93191311);

    cur_req = "R4";
    wr1(0, 8'h00);
    rd1(0);
    rd1(1);
    wr1(1, 8'h00);
    rd1(0);
    rd1(1);
    wr1(0, 8'h09);
    rd1(0);
    rd1(1);

    cur_req = "R8";
    rd1(3);
    wr1(3, 8'h03);
    rd1(3);

    cur_req = "R7 open";
    wr1(1, 8'hF3);
    wr1(2, 8'h31);
    wr1(4, 8'hE1);
    chk("R7 ier full", ier_o, 8'hF3);
    chk("R7 fcr full", fcr_o, 8'h31);
    chk("R7 mcr full", mcr_o, 8'hE1);
    rd1(1);
    rd1(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule